// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Access Controller

This block sits between a clocked host and an external 1M x16 pseudo-static RAM that has a plain asynchronous SRAM-style pin interface. The host hands over one word access at a time through a valid/ready handshake: a read/write flag, a 20-bit word address, 16 bits of write data and two byte-lane enables. The controller plays the access out as a fixed sequence of chip-enable, output-enable, write-enable and lane-enable levels on the memory pins. For a read it then returns the captured word with a one-cycle valid strobe.

Every analogue timing limit of the memory is given as a parameter in nanoseconds and turned into whole clock cycles by rounding up. These limits are the read cycle, address and output-enable access, write cycle, write pulse, data setup, write recovery, chip-enable high pulse and the longest allowed selected-but-idle time. All memory-side strobes come straight from flops, so they cannot glitch. The data bus is split into an output word, a drive enable and an input word, which a pad ring or a testbench joins into the shared bus. Power-up and deep power-down sequencing are not handled here.

Top module: `psram_async_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, chip enable, output enable, write enable and both lane enables are high (inactive), the bus drive enable is low and `req_ready` is high.
- R2: An accepted read drives chip enable and output enable low and write enable high for RD_LEN = max(ceil(T_RC/T), ceil(T_AA/T), ceil(T_OE/T)) cycles. The address stays unchanged for as long as chip enable is low.
- R3: Read data is captured at the clock edge that ends read cycle max(ceil(T_AA/T), ceil(T_OE/T)), counted from the cycle in which output enable first goes low. `rsp_valid` is high for exactly the one cycle that follows that edge.
- R4: Lane enable bit 1 gates data bits 15:8 and bit 0 gates bits 7:0, with host `req_be` bit i requesting lane i. A read with `req_be` = 2'b00 enables both lanes and returns the full word. Any other read enables only the requested lanes and returns zero in the others.
- R5: A write drives chip enable low with write enable high for a setup phase, then write enable low for ceil(T_WP/T) cycles, then write enable high for a hold phase. Setup plus pulse is at least ceil(T_DS/T), and the whole write lasts at least ceil(T_WC/T) cycles.
- R6: During a write the bus drive enable is high from the first setup cycle through the last hold cycle, `mem_dq_out` carries the write data, and lane enable i is low exactly when `req_be` bit i is set.
- R7: A write with `req_be` = 2'b00 changes no stored byte.
- R8: After every access chip enable stays high for at least ceil(T_CP/T) cycles before `req_ready` returns, and `req_ready` is low for the whole access.
- R9: The bus drive enable is never high while output enable is low, and it is low in the cycle before every falling edge of output enable.
- R10: Chip enable low with both output enable and write enable high never lasts longer than ceil(T_ODIS/T) consecutive cycles.
- R11: Between a rising and the next falling edge of write enable there are at least ceil(T_WR/T) cycles.
- R12: A read returns the bytes stored by earlier writes to the same address, merged lane by lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers an access |
| req_ready | output | 1 | Controller idle, access accepted when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane request, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle strobe, read data valid |
| rsp_rdata | output | 16 | Read data, unrequested lanes zero |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lane_n | output | 2 | Memory byte-lane enables, active low, bit 1 upper |
| mem_addr | output | 20 | Memory address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The hardest situation to reach is a read that follows a write to the same address as closely as the handshake allows. Here bus release before output enable, the chip-enable gap and freshly merged byte lanes all matter in the same few cycles. The bench reaches it by offering each request again as soon as the previous one is accepted. It mixes lane patterns, including the empty write and the empty read. Its memory model drives filler on disabled lanes and before the access time has run out, so a capture one cycle early or a missing lane mask shows up in the returned word.

// File: rtl/psram_ctl_pkg.sv
package psram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_GAP    = 3'd5
  } ctl_state_e;

  // Memory-side levels implied by a controller state.
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
    logic lanes;
  } strobe_t;

  // Round a nanosecond limit up to whole clock cycles.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic strobe_t strobes_for(input ctl_state_e s);
    strobe_t r;
    case (s)
      ST_READ:   r = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0, lanes: 1'b1};
      ST_WSETUP: r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1, lanes: 1'b1};
      ST_WPULSE: r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1, lanes: 1'b1};
      ST_WHOLD:  r = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1, lanes: 1'b1};
      default:   r = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0, lanes: 1'b0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/psram_phase_timer.sv
// Counts cycles spent in the current phase; the first cycle of a phase reads 1.
module psram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= ONE;
    end else if (restart) begin
      elapsed <= ONE;
    end else if (elapsed != '1) begin
      elapsed <= elapsed + ONE;
    end
  end

endmodule

// File: rtl/psram_lane_map.sv
// Host lane request to active-low memory lane enables. A read that asks for
// no lane is widened to all lanes, since partial-empty reads are not allowed.
module psram_lane_map #(
  parameter int BE_W = 2
) (
  input  logic            rd_op,
  input  logic [BE_W-1:0] be,
  output logic [BE_W-1:0] lane_n
);

  logic widen_all;
  assign widen_all = rd_op && (be == '0);

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign lane_n[i] = !(be[i] || widen_all);
  end

endmodule

// File: rtl/psram_read_capture.sv
// Samples the memory data bus and clears lanes that were not enabled.
module psram_read_capture #(
  parameter int DATA_W = 16,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [BE_W-1:0]   lane_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] keep_mask;

  for (genvar i = 0; i < BE_W; i++) begin : g_mask
    assign keep_mask[i*8 +: 8] = {8{~lane_n[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) begin
        rsp_data <= dq_in & keep_mask;
      end
    end
  end

endmodule

// File: rtl/psram_async_ctl.sv
module psram_async_ctl
  import psram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_RC_NS       = 80,
  parameter int T_AA_NS       = 60,
  parameter int T_OE_NS       = 35,
  parameter int T_WC_NS       = 80,
  parameter int T_WP_NS       = 45,
  parameter int T_DS_NS       = 15,
  parameter int T_WR_NS       = 20,
  parameter int T_CP_NS       = 10,
  parameter int T_ODIS_NS     = 1000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   mem_ce_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [DATA_W/8-1:0]    mem_lane_n,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_in
);

  localparam int BE_W      = DATA_W / 8;
  // Read: address and output enable become valid on the same edge, so the
  // later of the two access limits decides the sampling edge.
  localparam int AA_CYC    = ns_to_cycles(T_AA_NS, CLK_PERIOD_NS);
  localparam int OE_CYC    = ns_to_cycles(T_OE_NS, CLK_PERIOD_NS);
  localparam int RD_SAMPLE = imax(1, imax(AA_CYC, OE_CYC));
  localparam int RD_LEN    = imax(RD_SAMPLE, ns_to_cycles(T_RC_NS, CLK_PERIOD_NS));
  // Write: data is driven from the setup phase, so setup plus pulse covers
  // the data setup limit; the hold phase stretches the write to its cycle.
  localparam int WP_CYC    = imax(1, ns_to_cycles(T_WP_NS, CLK_PERIOD_NS));
  localparam int WS_CYC    = imax(1, ns_to_cycles(T_DS_NS, CLK_PERIOD_NS) - WP_CYC);
  localparam int WR_CYC    = ns_to_cycles(T_WR_NS, CLK_PERIOD_NS);
  localparam int WH_CYC    = imax(1, imax(WR_CYC,
                               ns_to_cycles(T_WC_NS, CLK_PERIOD_NS) - WS_CYC - WP_CYC));
  localparam int CP_CYC    = imax(1, ns_to_cycles(T_CP_NS, CLK_PERIOD_NS));
  localparam int ODIS_CYC  = ns_to_cycles(T_ODIS_NS, CLK_PERIOD_NS);
  localparam int CNT_W     = $clog2(RD_LEN + WS_CYC + WP_CYC + WH_CYC + CP_CYC + 2) + 1;

  localparam logic [CNT_W-1:0] RD_LEN_C    = CNT_W'(RD_LEN);
  localparam logic [CNT_W-1:0] RD_SAMPLE_C = CNT_W'(RD_SAMPLE);
  localparam logic [CNT_W-1:0] WS_C        = CNT_W'(WS_CYC);
  localparam logic [CNT_W-1:0] WP_C        = CNT_W'(WP_CYC);
  localparam logic [CNT_W-1:0] WH_C        = CNT_W'(WH_CYC);
  localparam logic [CNT_W-1:0] CP_C        = CNT_W'(CP_CYC);

  ctl_state_e          state_q;
  ctl_state_e          state_d;
  logic [CNT_W-1:0]    phase_cnt;
  logic                phase_restart;
  logic                op_write_q;
  logic [BE_W-1:0]     be_q;

  // Named internal events, used by the bound checker.
  logic                host_accept;
  logic                rd_capture;
  logic                phase_done;

  logic                op_write_d;
  logic [BE_W-1:0]     be_d;
  logic [BE_W-1:0]     lane_d;
  strobe_t             strobe_d;

  assign req_ready   = (state_q == ST_IDLE);
  assign host_accept = req_ready && req_valid;
  assign op_write_d  = host_accept ? req_write : op_write_q;
  assign be_d        = host_accept ? req_be : be_q;
  assign strobe_d    = strobes_for(state_d);

  // Phase length check for the current state.
  always_comb begin
    case (state_q)
      ST_READ:   phase_done = (phase_cnt == RD_LEN_C);
      ST_WSETUP: phase_done = (phase_cnt == WS_C);
      ST_WPULSE: phase_done = (phase_cnt == WP_C);
      ST_WHOLD:  phase_done = (phase_cnt == WH_C);
      ST_GAP:    phase_done = (phase_cnt == CP_C);
      default:   phase_done = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (host_accept) state_d = req_write ? ST_WSETUP : ST_READ;
      ST_READ:   if (phase_done)  state_d = ST_GAP;
      ST_WSETUP: if (phase_done)  state_d = ST_WPULSE;
      ST_WPULSE: if (phase_done)  state_d = ST_WHOLD;
      ST_WHOLD:  if (phase_done)  state_d = ST_GAP;
      ST_GAP:    if (phase_done)  state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  assign phase_restart = (state_d != state_q);
  assign rd_capture    = (state_q == ST_READ) && (phase_cnt == RD_SAMPLE_C);

  psram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_restart),
    .elapsed (phase_cnt)
  );

  psram_lane_map #(.BE_W(BE_W)) u_lanes (
    .rd_op  (!op_write_d),
    .be     (be_d),
    .lane_n (lane_d)
  );

  // State and registered memory pins; pins follow the next state so that
  // they change on the same edge as the state without a decode stage after it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_write_q <= 1'b0;
      be_q       <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_lane_n <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else begin
      state_q    <= state_d;
      op_write_q <= op_write_d;
      be_q       <= be_d;
      mem_ce_n   <= strobe_d.ce_n;
      mem_oe_n   <= strobe_d.oe_n;
      mem_we_n   <= strobe_d.we_n;
      mem_dq_oe  <= strobe_d.drive;
      mem_lane_n <= strobe_d.lanes ? lane_d : '1;
      if (host_accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
    end
  end

  psram_read_capture #(.DATA_W(DATA_W), .BE_W(BE_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_capture),
    .dq_in     (mem_dq_in),
    .lane_n    (mem_lane_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata)
  );

endmodule

// File: rtl/psram_ctl_checker.sv
module psram_ctl_checker #(
  parameter int ADDR_W   = 20,
  parameter int BE_W     = 2,
  parameter int WP_CYC   = 3,
  parameter int WR_CYC   = 1,
  parameter int CP_CYC   = 1,
  parameter int ODIS_CYC = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rd_capture,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [BE_W-1:0]   mem_lane_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  logic [15:0] wlow_run;
  logic [15:0] whigh_run;
  logic [15:0] cehigh_run;
  logic [15:0] odis_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wlow_run   <= '0;
      whigh_run  <= '1;
      cehigh_run <= '1;
      odis_run   <= '0;
    end else begin
      wlow_run   <= mem_we_n ? '0 : ((wlow_run == '1) ? wlow_run : wlow_run + 16'd1);
      whigh_run  <= !mem_we_n ? '0 : ((whigh_run == '1) ? whigh_run : whigh_run + 16'd1);
      cehigh_run <= !mem_ce_n ? '0 : ((cehigh_run == '1) ? cehigh_run : cehigh_run + 16'd1);
      odis_run   <= (!mem_ce_n && mem_oe_n && mem_we_n)
                    ? ((odis_run == '1) ? odis_run : odis_run + 16'd1) : '0;
    end
  end

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R3
  capture_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R4
  read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_lane_n != '1));

  // R5
  wpulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_run >= 16'(WP_CYC)));

  // R8
  cegap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (cehigh_run >= 16'(CP_CYC)));

  // R9
  drive_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R9
  release_before_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R10
  odis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odis_run <= 16'(ODIS_CYC));

  // R11
  wrec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (whigh_run >= 16'(WR_CYC)));

endmodule

bind psram_async_ctl psram_ctl_checker #(
  .ADDR_W   (ADDR_W),
  .BE_W     (BE_W),
  .WP_CYC   (WP_CYC),
  .WR_CYC   (WR_CYC),
  .CP_CYC   (CP_CYC),
  .ODIS_CYC (ODIS_CYC)
) u_psram_ctl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rd_capture (rd_capture),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lane_n (mem_lane_n),
  .mem_addr   (mem_addr),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/test_psram_async_ctl.sv
`timescale 1ns/1ps
module test_psram_async_ctl;

  localparam int PER = 20;

  function automatic int cdiv(input int ns);
    return (ns + PER - 1) / PER;
  endfunction
  function automatic int bmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bench-side cycle counts taken from the requirements.
  localparam int SAMPLE_B = bmax(cdiv(60), cdiv(35));
  localparam int RDLEN_B  = bmax(cdiv(80), SAMPLE_B);
  localparam int WP_B     = bmax(1, cdiv(45));
  localparam int WS_B     = bmax(1, cdiv(15) - WP_B);
  localparam int WH_B     = bmax(1, bmax(cdiv(20), cdiv(80) - WS_B - WP_B));
  localparam int CP_B     = bmax(1, cdiv(10));
  localparam int ODIS_B   = cdiv(1000);
  localparam int WR_B     = cdiv(20);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [19:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hDEAD;

  always #10 clk = ~clk;

  psram_async_ctl i_psram_async_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory model (asynchronous part behaviour) ----------
  logic [15:0] cells [int unsigned];
  int age = 0;

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      logic [15:0] w;
      w = cells.exists(mem_addr) ? cells[mem_addr] : 16'h0000;
      if (!mem_lane_n[1]) w[15:8] = mem_dq_out[15:8];
      if (!mem_lane_n[0]) w[7:0]  = mem_dq_out[7:0];
      cells[mem_addr] = w;
    end
  end

  always @(negedge clk) begin
    logic [15:0] w;
    if (!mem_ce_n && !mem_oe_n) age = age + 1; else age = 0;
    w = cells.exists(mem_addr) ? cells[mem_addr] : 16'h0000;
    if (mem_lane_n[1]) w[15:8] = 8'hEE;
    if (mem_lane_n[0]) w[7:0]  = 8'hEE;
    mem_dq_in = (age >= SAMPLE_B) ? w : 16'hDEAD;
  end

  // ---------------- reference model --------------------------------------
  typedef struct packed {
    logic [1:0] kind;   // 0 idle, 1 read, 2 write
    logic ce, oe, we;
    logic [1:0] lane;
    logic dqoe, rdy, rv;
  } exp_t;

  localparam exp_t IDLE_E = '{kind: 2'd0, ce: 1'b1, oe: 1'b1, we: 1'b1, lane: 2'b11,
                              dqoe: 1'b0, rdy: 1'b1, rv: 1'b0};

  exp_t        expq[$];
  logic [15:0] shadow [int unsigned];
  logic [19:0] cur_addr;
  logic [15:0] cur_wdata;
  logic [15:0] cur_rdata;
  string       cur_rtag = "R12";
  string       stim_tag = "R12";
  int          odis_run = 0, odis_max = 0, whigh = 1000;
  logic        prev_we = 1'b1;

  function automatic string strobe_tag(input logic [1:0] k);
    return (k == 2'd1) ? "R2" : ((k == 2'd2) ? "R5" : "R1");
  endfunction

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && !done) begin
      e = (expq.size() > 0) ? expq.pop_front() : IDLE_E;
      chk({mem_ce_n, mem_oe_n, mem_we_n} == {e.ce, e.oe, e.we}, strobe_tag(e.kind),
          {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, {29'd0, e.ce, e.oe, e.we});
      chk(mem_lane_n == e.lane, (e.kind == 2'd2) ? "R6" : "R4", {30'd0, mem_lane_n}, {30'd0, e.lane});
      chk(mem_dq_oe == e.dqoe, "R9", {31'd0, mem_dq_oe}, {31'd0, e.dqoe});
      chk(req_ready == e.rdy, "R8", {31'd0, req_ready}, {31'd0, e.rdy});
      chk(rsp_valid == e.rv, "R3", {31'd0, rsp_valid}, {31'd0, e.rv});
      if (!e.ce) chk(mem_addr == cur_addr, "R2", {12'd0, mem_addr}, {12'd0, cur_addr});
      if (e.dqoe) chk(mem_dq_out == cur_wdata, "R6", {16'd0, mem_dq_out}, {16'd0, cur_wdata});
      if (e.rv) chk(rsp_rdata == cur_rdata, cur_rtag, {16'd0, rsp_rdata}, {16'd0, cur_rdata});

      // R10: selected with both G and W high
      if (!mem_ce_n && mem_oe_n && mem_we_n) odis_run++; else odis_run = 0;
      if (odis_run > odis_max) odis_max = odis_run;
      // R11: W high time before each new fall
      if (prev_we && !mem_we_n) chk(whigh >= WR_B, "R11", whigh, WR_B);
      if (mem_we_n) whigh++; else whigh = 0;
      prev_we = mem_we_n;

      if (req_valid && req_ready) begin
        cur_addr  = req_addr;
        cur_wdata = req_wdata;
        if (req_write) begin
          logic [15:0] w;
          w = shadow.exists(req_addr) ? shadow[req_addr] : 16'h0000;
          if (req_be[1]) w[15:8] = req_wdata[15:8];
          if (req_be[0]) w[7:0]  = req_wdata[7:0];
          shadow[req_addr] = w;
          for (int i = 1; i <= WS_B + WP_B + WH_B; i++) begin
            exp_t x;
            x = '{kind: 2'd2, ce: 1'b0, oe: 1'b1,
                  we: (i > WS_B && i <= WS_B + WP_B) ? 1'b0 : 1'b1,
                  lane: ~req_be, dqoe: 1'b1, rdy: 1'b0, rv: 1'b0};
            expq.push_back(x);
          end
          for (int i = 1; i <= CP_B; i++) begin
            exp_t x;
            x = IDLE_E;
            x.kind = 2'd2;
            x.rdy  = 1'b0;
            expq.push_back(x);
          end
        end else begin
          logic [15:0] w;
          logic [1:0]  ln;
          w  = shadow.exists(req_addr) ? shadow[req_addr] : 16'h0000;
          ln = (req_be == 2'b00) ? 2'b00 : ~req_be;
          if (ln[1]) w[15:8] = 8'h00;
          if (ln[0]) w[7:0]  = 8'h00;
          cur_rdata = w;
          cur_rtag  = stim_tag;
          for (int i = 1; i <= RDLEN_B + CP_B; i++) begin
            exp_t x;
            if (i <= RDLEN_B)
              x = '{kind: 2'd1, ce: 1'b0, oe: 1'b0, we: 1'b1, lane: ln,
                    dqoe: 1'b0, rdy: 1'b0, rv: 1'b0};
            else begin
              x = IDLE_E;
              x.kind = 2'd1;
              x.rdy  = 1'b0;
            end
            x.rv = (i == SAMPLE_B + 1);
            expq.push_back(x);
          end
        end
      end
    end
  end

  // ---------------- stimulus -------------------------------------------
  task automatic issue(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be, input string tag);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    stim_tag = tag;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
    req_addr  = ~a;          // scrambled while busy, must not reach the pins
    req_wdata = ~d;
    req_be    = ~be;
  endtask

  task automatic drain();
    repeat (RDLEN_B + WS_B + WP_B + WH_B + CP_B + 3) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && mem_lane_n == 2'b11,
        "R1", {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready, rsp_valid},
        {26'd0, 6'b111010});

    issue(1'b1, 20'h00010, 16'h1234, 2'b11, "R6");
    issue(1'b0, 20'h00010, 16'h0000, 2'b11, "R12");   // back-to-back read after write
    issue(1'b1, 20'h00010, 16'hABCD, 2'b10, "R6");    // upper lane only
    issue(1'b0, 20'h00010, 16'h0000, 2'b00, "R4");    // empty read -> full word 0xAB34
    issue(1'b0, 20'h00010, 16'h0000, 2'b01, "R4");    // lower only -> 0x0034
    issue(1'b0, 20'h00010, 16'h0000, 2'b10, "R4");    // upper only -> 0xAB00
    issue(1'b1, 20'h00010, 16'hFFFF, 2'b00, "R7");    // empty write
    issue(1'b0, 20'h00010, 16'h0000, 2'b11, "R7");    // still 0xAB34
    issue(1'b1, 20'hFFFFF, 16'h5A5A, 2'b01, "R6");
    issue(1'b0, 20'hFFFFF, 16'h0000, 2'b11, "R12");   // 0x005A
    issue(1'b0, 20'h33333, 16'h0000, 2'b11, "R12");   // never written -> 0
    drain();

    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 40; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      issue(1'b1, {14'd0, lf[5:0]}, lf[31:16], lf[9:8], "R5");
    end
    for (int n = 0; n < 40; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      issue(1'b0, {14'd0, lf[5:0]}, 16'h0000, lf[9:8], "R12");
    end
    drain();

    // R10: longest selected-idle run
    chk(odis_max <= ODIS_B && odis_max > 0, "R10", odis_max, ODIS_B);
    @(negedge clk);
    chk(req_ready && mem_ce_n && !mem_dq_oe, "R1", {30'd0, req_ready, mem_ce_n}, {30'd0, 2'b11});
    finish_run();
  end

endmodule